// File: doc/BRIEF.md
# Dual 16-bit Interval Timer

This block holds two 16-bit down-counters, each fed by its own 16-bit reload latch. Software reaches them through a byte-wide register port: a 4-bit address, one-byte write data, write and read strobes, and a registered one-byte read data output. The counters advance only in cycles where the count enable input is high. The caller can therefore derive the count rate from any prescaler.

Timer 1 is either periodic or single-shot, chosen by a mode input that comes from an auxiliary control register outside the block. In periodic mode it counts from the latch value down through zero to all-ones, then reloads, so each period is latch + 2 counts. Timer 2 is always single-shot. Each timer has one output that pulses when its count arrives at zero, and one output that pulses when software acknowledges the event. An interrupt flag and enable stage outside the block consumes these four pulses.

Register map (4-bit address):

| Address | Write | Read |
|---------|-------|------|
| 0 | timer 1 latch low byte | timer 1 count low byte, acknowledges timer 1 |
| 1 | timer 1 latch high byte, then load the counter | timer 1 count high byte |
| 2 | timer 1 latch low byte | timer 1 latch low byte |
| 3 | timer 1 latch high byte, no load | timer 1 latch high byte |
| 4 | timer 2 latch low byte | timer 2 count low byte, acknowledges timer 2 |
| 5 | timer 2 latch high byte, then load the counter | timer 2 count high byte |
| 6..15 | ignored | reads 0x00 |

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, both latches and the timer 1 counter are 0xFFFF. All four pulse outputs are low and rdata is 0x00.
- R2: A write to address 0 or 2 replaces only the low byte of the timer 1 latch. It leaves the timer 1 counter unchanged.
- R3: A write to address 1 sets the timer 1 latch high byte and copies the full 16-bit latch into the counter. It also pulses t1_flag_clr in the following cycle.
- R4: A write to address 3 sets the timer 1 latch high byte and pulses t1_flag_clr in the following cycle. It does not reload the counter.
- R5: Each counter drops by one on every clock edge where cnt_en is high. At an edge where the timer's counter is also loaded by a register write, the load takes priority.
- R6: With t1_free_run high, timer 1 steps from the latch value L down to 0, then to 0xFFFF, then back to L, for a period of L + 2 enabled edges. t1_flag_set pulses for one cycle each time the count becomes zero, and is high in the same cycle that the count reads zero.
- R7: With t1_free_run low, timer 1 pulses t1_flag_set once on reaching zero after a load. It then keeps wrapping downward without a further pulse until it is loaded again.
- R8: A write to address 4 sets only the timer 2 latch low byte. A write to address 5 sets the timer 2 latch high byte, loads the timer 2 counter from the latch, and pulses t2_flag_clr in the following cycle.
- R9: Timer 2 pulses t2_flag_set once on reaching zero after each load. It keeps decrementing afterwards with no further pulse.
- R10: Reading address 0 or 4 returns the low byte of that timer's live count and pulses that timer's clear output. Reading address 1 or 5 returns the high byte and pulses no clear output.
- R11: Reading address 2 or 3 returns the stored timer 1 latch byte and changes no state.
- R12: rdata takes the selected value at the edge where rd_en is high, and holds it until the next read. Addresses 6 to 15 read as 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable, one decrement per high cycle |
| t1_free_run | input | 1 | Timer 1 mode: 1 periodic, 0 single-shot |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| t1_flag_set | output | 1 | Timer 1 reached zero (one-cycle pulse) |
| t2_flag_set | output | 1 | Timer 2 reached zero (one-cycle pulse) |
| t1_flag_clr | output | 1 | Timer 1 event acknowledged (one-cycle pulse) |
| t2_flag_clr | output | 1 | Timer 2 event acknowledged (one-cycle pulse) |

## Verification
The hardest thing to observe from the ports is the wrap-and-reload sequence of periodic timer 1. The count sits at 0xFFFF for exactly one enabled edge and then jumps back to the latch value. The bench loads a small latch and drives cnt_en for an exact number of edges, stopping once just after the wrap and once just after the reload. It then reads the count bytes while the counter is frozen. For the single-shot case it runs well past the zero crossing and counts the set pulses.

// File: rtl/dit_pkg.sv
package dit_pkg;

  localparam int REG_ADDR_W = 4;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_T1_CNT_LO = 4'd0,
    RA_T1_CNT_HI = 4'd1,
    RA_T1_LAT_LO = 4'd2,
    RA_T1_LAT_HI = 4'd3,
    RA_T2_LO     = 4'd4,
    RA_T2_HI     = 4'd5
  } reg_addr_e;

  // per-timer strobes produced by the address decoder
  typedef struct packed {
    logic lat_lo;   // replace latch low byte
    logic lat_hi;   // replace latch high byte
    logic load;     // copy latch (with new high byte) into the counter
    logic ack;      // acknowledge: pulse the clear output
  } tmr_strobe_t;

endpackage

// File: rtl/dit_rst_sync.sv
module dit_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dit_decode.sv
module dit_decode
  import dit_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output tmr_strobe_t       st1,
  output tmr_strobe_t       st2
);

  logic a_t1_clo, a_t1_chi, a_t1_llo, a_t1_lhi, a_t2_lo, a_t2_hi;

  always_comb begin
    a_t1_clo = (addr == ADDR_W'(RA_T1_CNT_LO));
    a_t1_chi = (addr == ADDR_W'(RA_T1_CNT_HI));
    a_t1_llo = (addr == ADDR_W'(RA_T1_LAT_LO));
    a_t1_lhi = (addr == ADDR_W'(RA_T1_LAT_HI));
    a_t2_lo  = (addr == ADDR_W'(RA_T2_LO));
    a_t2_hi  = (addr == ADDR_W'(RA_T2_HI));
  end

  always_comb begin
    st1.lat_lo = wr_en & (a_t1_clo | a_t1_llo);
    st1.lat_hi = wr_en & (a_t1_chi | a_t1_lhi);
    st1.load   = wr_en & a_t1_chi;
    st1.ack    = (wr_en & (a_t1_chi | a_t1_lhi)) | (rd_en & a_t1_clo);

    st2.lat_lo = wr_en & a_t2_lo;
    st2.lat_hi = wr_en & a_t2_hi;
    st2.load   = wr_en & a_t2_hi;
    st2.ack    = (wr_en & a_t2_hi) | (rd_en & a_t2_lo);
  end

endmodule

// File: rtl/dit_timer.sv
module dit_timer
  import dit_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int CAN_RELOAD = 1,  // 1: periodic mode available
  parameter int ARM_RST    = 1,  // 1: armed for one event out of reset
  localparam int CNT_W     = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              free_run,
  input  tmr_strobe_t       st,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  latch,
  output logic              fire,
  output logic              ack
);

  logic [CNT_W-1:0] lat_q, lat_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap_q, wrap_d;   // counter sits at all-ones after passing zero
  logic             arm_q, arm_d;     // single-shot event still pending
  logic             fire_q, fire_d;
  logic             ack_q;
  logic             cont;
  logic             lat_we, cnt_we;

  generate
    if (CAN_RELOAD != 0) begin : g_periodic
      assign cont = free_run;
    end else begin : g_single
      assign cont = free_run & 1'b0;
    end
  endgenerate

  assign lat_we = st.lat_lo | st.lat_hi;
  assign cnt_we = st.load | step;

  // next-state
  always_comb begin
    lat_d = lat_q;
    if (st.lat_lo) lat_d[BYTE_W-1:0]     = wbyte;
    if (st.lat_hi) lat_d[CNT_W-1:BYTE_W] = wbyte;
  end

  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = wrap_q;
    arm_d  = arm_q;
    fire_d = 1'b0;
    if (st.load) begin
      cnt_d  = {wbyte, lat_q[BYTE_W-1:0]};
      wrap_d = 1'b0;
      arm_d  = 1'b1;
    end else if (step) begin
      if (cont && wrap_q) begin
        cnt_d  = lat_q;
        wrap_d = 1'b0;
      end else begin
        cnt_d  = cnt_q - 1'b1;
        wrap_d = cont && (cnt_q == '0);
      end
      if (cnt_d == '0) begin
        fire_d = cont | arm_q;
        arm_d  = 1'b0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '1;
      cnt_q  <= '1;
      wrap_q <= 1'b0;
      arm_q  <= (ARM_RST != 0);
      fire_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      if (lat_we) begin
        lat_q <= lat_d;
      end
      if (cnt_we) begin
        cnt_q  <= cnt_d;
        wrap_q <= wrap_d;
        arm_q  <= arm_d;
      end
      fire_q <= fire_d;
      ack_q  <= st.ack;
    end
  end

  assign count = cnt_q;
  assign latch = lat_q;
  assign fire  = fire_q;
  assign ack   = ack_q;

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = REG_ADDR_W,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              t1_free_run,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              t1_flag_set,
  output logic              t2_flag_set,
  output logic              t1_flag_clr,
  output logic              t2_flag_clr
);

  logic             rst_sync_n;
  tmr_strobe_t      st1, st2;
  logic [CNT_W-1:0] t1_count, t1_latch, t2_count, t2_latch;
  logic [BYTE_W-1:0] rd_mux, rdata_q;
  logic [CNT_W-1:0]  t2_latch_unused;

  dit_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dit_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .st1   (st1),
    .st2   (st2)
  );

  dit_timer #(.BYTE_W(BYTE_W), .CAN_RELOAD(1), .ARM_RST(1)) u_t1 (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .step     (cnt_en),
    .free_run (t1_free_run),
    .st       (st1),
    .wbyte    (wdata),
    .count    (t1_count),
    .latch    (t1_latch),
    .fire     (t1_flag_set),
    .ack      (t1_flag_clr)
  );

  dit_timer #(.BYTE_W(BYTE_W), .CAN_RELOAD(0), .ARM_RST(0)) u_t2 (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .step     (cnt_en),
    .free_run (1'b0),
    .st       (st2),
    .wbyte    (wdata),
    .count    (t2_count),
    .latch    (t2_latch),
    .fire     (t2_flag_set),
    .ack      (t2_flag_clr)
  );

  // timer 2 latch is only reachable through its counter load
  assign t2_latch_unused = t2_latch;

  // read selection
  always_comb begin
    case (addr)
      ADDR_W'(RA_T1_CNT_LO): rd_mux = t1_count[BYTE_W-1:0];
      ADDR_W'(RA_T1_CNT_HI): rd_mux = t1_count[CNT_W-1:BYTE_W];
      ADDR_W'(RA_T1_LAT_LO): rd_mux = t1_latch[BYTE_W-1:0];
      ADDR_W'(RA_T1_LAT_HI): rd_mux = t1_latch[CNT_W-1:BYTE_W];
      ADDR_W'(RA_T2_LO):     rd_mux = t2_count[BYTE_W-1:0];
      ADDR_W'(RA_T2_HI):     rd_mux = t2_count[CNT_W-1:BYTE_W];
      default:               rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_mux;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/dit_checker.sv
module dit_checker #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 4,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic              t1_free_run,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTE_W-1:0] wdata,
  input logic              t1_flag_set,
  input logic              t2_flag_set,
  input logic              t1_flag_clr,
  input logic              t2_flag_clr,
  input logic [CNT_W-1:0]  t1_count,
  input logic [CNT_W-1:0]  t1_latch,
  input logic [CNT_W-1:0]  t2_count,
  input logic [CNT_W-1:0]  t2_latch
);

  p_low_write_keeps_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == ADDR_W'(2)) && !cnt_en) |=> (t1_count == $past(t1_count)));

  p_high_write_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == ADDR_W'(1)))
      |=> (t1_count == {$past(wdata), $past(t1_latch[BYTE_W-1:0])}) && t1_flag_clr);

  p_latch_high_no_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == ADDR_W'(3)) && !cnt_en)
      |=> (t1_count == $past(t1_count)) && t1_flag_clr);

  p_single_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !t1_free_run && !(wr_en && (addr == ADDR_W'(1))))
      |=> (t1_count == $past(t1_count) - 1'b1));

  p_set_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    t1_flag_set |-> (t1_count == '0) && $past(cnt_en));

  p_zero_wraps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && (t1_count == '0) && !(wr_en && (addr == ADDR_W'(1))))
      |=> (t1_count == '1));

  p_t2_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == ADDR_W'(5)))
      |=> (t2_count == {$past(wdata), $past(t2_latch[BYTE_W-1:0])}) && t2_flag_clr);

  p_t2_set_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    t2_flag_set |-> (t2_count == '0));

  p_read_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && (addr == ADDR_W'(0))) |=> t1_flag_clr);

  p_latch_read_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && ((addr == ADDR_W'(2)) || (addr == ADDR_W'(3))))
      |=> $stable(t1_latch) && !t1_flag_clr && !t2_flag_clr);

  p_unmapped_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr > ADDR_W'(5))) |=> $stable(t1_latch) && $stable(t2_latch));

endmodule

bind dual_interval_timer dit_checker #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cnt_en      (cnt_en),
  .t1_free_run (t1_free_run),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .addr        (addr),
  .wdata       (wdata),
  .t1_flag_set (t1_flag_set),
  .t2_flag_set (t2_flag_set),
  .t1_flag_clr (t1_flag_clr),
  .t2_flag_clr (t2_flag_clr),
  .t1_count    (t1_count),
  .t1_latch    (t1_latch),
  .t2_count    (t2_count),
  .t2_latch    (t2_latch)
);

// File: tb/sim_dual_interval_timer.sv
`timescale 1ns/1ps
module sim_dual_interval_timer;

  logic       clk = 1'b0;
  logic       rst_n, cnt_en, t1_free_run, wr_en, rd_en;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic       t1_flag_set, t2_flag_set, t1_flag_clr, t2_flag_clr;

  int total = 0;
  int bad   = 0;
  logic [7:0] got_rd;
  logic [1:0] got_clr;
  int p1_cnt, p1_first, p1_last, p2_cnt, p2_first;

  always #5 clk = ~clk;

  dual_interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .t1_free_run(t1_free_run),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .t1_flag_set(t1_flag_set), .t2_flag_set(t2_flag_set),
    .t1_flag_clr(t1_flag_clr), .t2_flag_clr(t2_flag_clr)
  );

  typedef struct packed {
    logic       wr;
    logic [3:0] a;
    logic [7:0] d;    // write data, or expected read data
    logic [1:0] clr;  // expected {t2_flag_clr, t1_flag_clr} after the access
    logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'h0, 8'h34, 2'b00, 4'd2},   // R2 latch low via count-low address
    '{1'b0, 4'h2, 8'h34, 2'b00, 4'd2},   // R2 latch low updated
    '{1'b0, 4'h0, 8'hFF, 2'b01, 4'd2},   // R2 count untouched, R10 ack pulse
    '{1'b1, 4'h1, 8'h12, 2'b01, 4'd3},   // R3 load + ack
    '{1'b0, 4'h0, 8'h34, 2'b01, 4'd3},   // R3 count low loaded
    '{1'b0, 4'h1, 8'h12, 2'b00, 4'd3},   // R3 count high, R10 no ack on high
    '{1'b1, 4'h2, 8'h56, 2'b00, 4'd2},   // R2 latch low only
    '{1'b0, 4'h0, 8'h34, 2'b01, 4'd2},   // R2 count unchanged
    '{1'b0, 4'h2, 8'h56, 2'b00, 4'd11},  // R11 latch read, no ack
    '{1'b1, 4'h3, 8'h78, 2'b01, 4'd4},   // R4 ack, no load
    '{1'b0, 4'h1, 8'h12, 2'b00, 4'd4},   // R4 count high unchanged
    '{1'b0, 4'h3, 8'h78, 2'b00, 4'd11},  // R11 latch high read
    '{1'b1, 4'h4, 8'h9A, 2'b00, 4'd8},   // R8 t2 latch low, no ack
    '{1'b1, 4'h5, 8'hBC, 2'b10, 4'd8},   // R8 t2 load + ack
    '{1'b0, 4'h4, 8'h9A, 2'b10, 4'd8},   // R8 t2 count low, R10 t2 ack
    '{1'b0, 4'h5, 8'hBC, 2'b00, 4'd10},  // R10 t2 count high, no ack
    '{1'b1, 4'h9, 8'hEE, 2'b00, 4'd12},  // R12 unmapped write
    '{1'b0, 4'h9, 8'h00, 2'b00, 4'd12},  // R12 unmapped read
    '{1'b0, 4'h2, 8'h56, 2'b00, 4'd12},  // R12 latch intact
    '{1'b0, 4'h3, 8'h78, 2'b00, 4'd12}   // R12 latch intact
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one register access; results sampled half a cycle after the edge
  task automatic access(input logic w, input logic [3:0] a, input logic [7:0] d);
    wr_en = w; rd_en = ~w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    got_rd  = rdata;
    got_clr = {t2_flag_clr, t1_flag_clr};
  endtask

  task automatic run(input int n);
    p1_cnt = 0; p1_first = -1; p1_last = -1; p2_cnt = 0; p2_first = -1;
    cnt_en = 1'b1;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == n) cnt_en = 1'b0;
      if (t1_flag_set) begin
        p1_cnt++; p1_last = i;
        if (p1_first < 0) p1_first = i;
      end
      if (t2_flag_set) begin
        p2_cnt++;
        if (p2_first < 0) p2_first = i;
      end
    end
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_en = 1'b0; t1_free_run = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 pulses", {t1_flag_set, t2_flag_set, t1_flag_clr, t2_flag_clr}, 0);
    check("R1 rdata", rdata, 8'h00);
    access(1'b0, 4'h2, 8'h00); check("R1 latch lo", got_rd, 8'hFF);
    access(1'b0, 4'h3, 8'h00); check("R1 latch hi", got_rd, 8'hFF);
    access(1'b0, 4'h1, 8'h00); check("R1 count hi", got_rd, 8'hFF);

    // vector table
    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[k].req, k);
      access(VEC[k].wr, VEC[k].a, VEC[k].d);
      if (!VEC[k].wr) check(tag, got_rd, VEC[k].d);
      check({tag, " clr"}, got_clr, VEC[k].clr);
    end

    // R5 load has priority over a concurrent count step
    access(1'b1, 4'h0, 8'h10);
    cnt_en = 1'b1;
    access(1'b1, 4'h1, 8'h00);
    cnt_en = 1'b0;
    access(1'b0, 4'h0, 8'h00); check("R5 load wins", got_rd, 8'h10);
    run(3);
    access(1'b0, 4'h0, 8'h00); check("R5 three steps", got_rd, 8'h0D);

    // R6 periodic: wrap to all-ones, then reload
    t1_free_run = 1'b1;
    access(1'b1, 4'h0, 8'h03);
    access(1'b1, 4'h1, 8'h00);
    run(4);
    check("R6 zero pulse at step 3", p1_first, 3);
    access(1'b0, 4'h0, 8'h00); check("R6 wrap lo", got_rd, 8'hFF);
    access(1'b0, 4'h1, 8'h00); check("R6 wrap hi", got_rd, 8'hFF);
    run(1);
    access(1'b0, 4'h0, 8'h00); check("R6 reload lo", got_rd, 8'h03);
    access(1'b0, 4'h1, 8'h00); check("R6 reload hi", got_rd, 8'h00);
    access(1'b1, 4'h1, 8'h00);
    run(20);
    check("R6 pulse count", p1_cnt, 4);
    check("R6 first pulse", p1_first, 3);
    check("R6 last pulse", p1_last, 18);

    // R7 single-shot timer 1
    t1_free_run = 1'b0;
    access(1'b1, 4'h0, 8'h02);
    access(1'b1, 4'h1, 8'h00);
    run(40);
    check("R7 pulse count", p1_cnt, 1);
    check("R7 pulse step", p1_first, 2);
    access(1'b0, 4'h0, 8'h00); check("R7 wrapped lo", got_rd, 8'hDA);
    access(1'b0, 4'h1, 8'h00); check("R7 wrapped hi", got_rd, 8'hFF);

    // R9 timer 2 single-shot, rearmed by reload
    access(1'b1, 4'h4, 8'h02);
    access(1'b1, 4'h5, 8'h00);
    check("R8 t2 ack on load", got_clr, 2'b10);
    run(40);
    check("R9 t2 pulse count", p2_cnt, 1);
    check("R9 t2 pulse step", p2_first, 2);
    access(1'b1, 4'h5, 8'h00);
    run(5);
    check("R9 t2 rearmed", p2_cnt, 1);
    check("R9 t2 rearmed step", p2_first, 2);
    access(1'b0, 4'h4, 8'h00); check("R9 t2 count lo", got_rd, 8'hFD);
    check("R10 t2 read ack", got_clr, 2'b10);
    access(1'b0, 4'h5, 8'h00); check("R9 t2 count hi", got_rd, 8'hFF);

    // R12 rdata holds between reads
    repeat (3) @(negedge clk);
    check("R12 rdata hold", rdata, 8'hFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule